// File: doc/BRIEF.md
# Privileged Register Read Unit

This block is the read side of a processor's control and status register file. It keeps the machine-level state that reads depend on: status, interrupt pending and enable words, the interrupt delegation mask, trap vectors, exception PC, cause, faulting address, scratch words, page-table base, the floating-point flags and rounding mode, two 64-bit counters, and two counter-enable masks. A read request names a 12-bit register address and the current register width mode, either 32 or 64 bits. One cycle later the block returns the value or flags the access as illegal.

Supervisor registers are not stored a second time. Most are views of the machine state, cut down by fixed masks or by the delegation mask. User and supervisor counter aliases are allowed only when the matching bit of a per-privilege enable mask is set. A plain write port loads the stored state. It exists so that state can be set up; it is not a full architectural write path.

Top module: `csr_read_unit`

## Requirements
- R1: A read is registered. `rd_valid` is high in the cycle after a cycle with `read_en` high and low otherwise. Reset clears `rd_valid`, `rdata` and `illegal`.
- R2: Stored machine registers read back the value last written. Mstatus is at 0x300, mie at 0x304, mip at 0x344 and mepc at 0x341. In 32-bit mode (`xlen64`=0), every legal read returns the low 32 bits and zero in bits 63:32.
- R3: Supervisor status (0x100) returns machine status ANDed with mask 0x5E122. That mask keeps SIE bit 1, SPIE bit 5, SPP bit 8, FS bits 14:13, XS bits 16:15 and PUM bit 18. The summary bit is set when FS or XS is all ones. It sits at bit 63 in 64-bit mode and at bit 31 in 32-bit mode.
- R4: Supervisor interrupt pending (0x144) is mip AND mideleg (0x303). Supervisor interrupt enable (0x104) is mie AND mideleg.
- R5: Flags (0x001) return 5 bits and rounding mode (0x002) returns 3 bits. The combined word (0x003) is flags | (mode << 5). All three are illegal when `fp_en` is low.
- R6: User aliases are cycle 0xC00, time 0xC01 and instret 0xC02. Each is legal only when bit addr[4:0] of the user enable mask (0x320) is set. Cycle and time return the cycle counter, and instret returns the retire counter.
- R7: Supervisor aliases 0xD00 to 0xD02 behave the same way, but are gated by the supervisor enable mask (0x321).
- R8: The cycle counter (0xB00) increments every clock. The retire counter (0xB02) increments on each cycle with `retire` high. A write to either counter wins over counting. The high halves at 0xB80 and 0xB82 return bits 63:32 in 32-bit mode and are illegal in 64-bit mode.
- R9: Delta registers 0x700 to 0x702 and 0x704 to 0x706 read zero. Their high halves, at the same addresses plus 0x80, read zero in 32-bit mode and are illegal in 64-bit mode.
- R10: Vendor 0xF11, architecture 0xF12, implementation 0xF13, interrupt inject 0x345 and address-space ID 0x181 read zero. Hart ID 0xF14 returns `HART_ID`, and ISA 0x301 returns `ISA_MASK`.
- R11: In 32-bit mode, supervisor cause (0x142) returns the stored value with stored bit 63 ORed into bit 31.
- R12: Any address not in the map is illegal, and an illegal read returns `rdata` = 0.
- R13: Writes to addresses that have no storage (views, constants, aliases) change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_en | input | 1 | Read request |
| addr | input | 12 | Read address |
| xlen64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| fp_en | input | 1 | Floating-point state enabled |
| retire | input | 1 | One instruction retired this cycle |
| wr_en | input | 1 | State load strobe |
| wr_addr | input | 12 | State load address |
| wr_data | input | 64 | State load data |
| rd_valid | output | 1 | Read result valid |
| rdata | output | 64 | Read data |
| illegal | output | 1 | Read raised illegal instruction |

## Verification
The read result, together with its illegal flag, appears exactly one clock after the edge that captures `read_en`. The bench therefore drives each request at a falling edge and samples `rdata`, `illegal` and `rd_valid` at the next falling edge. A write loaded at one edge is visible to a read issued in the following cycle. Counter reads capture the value held before that cycle's increment, so after a counter write the bench predicts each later read by counting one cycle per intervening operation, or one retire per pulsed cycle.

// File: rtl/csr_read_unit.sv
module csr_read_unit #(
  parameter logic [63:0] HART_ID  = 64'd0,
  parameter logic [63:0] ISA_MASK = 64'h8000_0000_0014_112D,
  parameter bit          HAS_FP   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        read_en,
  input  logic [11:0] addr,
  input  logic        xlen64,
  input  logic        fp_en,
  input  logic        retire,
  input  logic        wr_en,
  input  logic [11:0] wr_addr,
  input  logic [63:0] wr_data,
  output logic        rd_valid,
  output logic [63:0] rdata,
  output logic        illegal
);
  localparam logic [11:0] A_FLAGS = 12'h001, A_RMODE = 12'h002, A_FPALL = 12'h003;
  localparam logic [11:0] A_SSTAT = 12'h100, A_SIE = 12'h104, A_STVEC = 12'h105;
  localparam logic [11:0] A_SSCR = 12'h140, A_SEPC = 12'h141, A_SCAUSE = 12'h142;
  localparam logic [11:0] A_SBAD = 12'h143, A_SIP = 12'h144, A_SPTB = 12'h180, A_SASID = 12'h181;
  localparam logic [11:0] A_MSTAT = 12'h300, A_ISA = 12'h301, A_EDLG = 12'h302, A_IDLG = 12'h303;
  localparam logic [11:0] A_MIE = 12'h304, A_MTVEC = 12'h305, A_UCEN = 12'h320, A_SCEN = 12'h321;
  localparam logic [11:0] A_MSCR = 12'h340, A_MEPC = 12'h341, A_MCAUSE = 12'h342;
  localparam logic [11:0] A_MBAD = 12'h343, A_MIP = 12'h344, A_MINJ = 12'h345;
  localparam logic [11:0] A_MCYC = 12'hB00, A_MINS = 12'hB02, A_MCYCH = 12'hB80, A_MINSH = 12'hB82;
  localparam logic [11:0] A_UCYC = 12'hC00, A_UTIM = 12'hC01, A_UINS = 12'hC02;
  localparam logic [11:0] A_SCYC = 12'hD00, A_STIM = 12'hD01, A_SINS = 12'hD02;
  localparam logic [11:0] A_VEND = 12'hF11, A_ARCH = 12'hF12, A_IMPL = 12'hF13, A_HART = 12'hF14;
  localparam logic [63:0] SVIEW_MASK = 64'h0000_0000_0005_E122;

  logic [63:0] mstat_q, mip_q, mie_q, edlg_q, idlg_q, mtvec_q, mscr_q, mepc_q;
  logic [63:0] mcause_q, mbad_q, sepc_q, scause_q, sbad_q, stvec_q, sscr_q, sptb_q;
  logic [31:0] ucen_q, scen_q;
  logic [4:0]  flags_q;
  logic [2:0]  rmode_q;
  logic [63:0] cyc_q, ins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstat_q <= '0; mip_q <= '0; mie_q <= '0; edlg_q <= '0; idlg_q <= '0;
      mtvec_q <= '0; mscr_q <= '0; mepc_q <= '0; mcause_q <= '0; mbad_q <= '0;
      sepc_q <= '0; scause_q <= '0; sbad_q <= '0; stvec_q <= '0; sscr_q <= '0;
      sptb_q <= '0; ucen_q <= '0; scen_q <= '0; flags_q <= '0; rmode_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MSTAT:  mstat_q  <= wr_data;
        A_MIP:    mip_q    <= wr_data;
        A_MIE:    mie_q    <= wr_data;
        A_EDLG:   edlg_q   <= wr_data;
        A_IDLG:   idlg_q   <= wr_data;
        A_MTVEC:  mtvec_q  <= wr_data;
        A_MSCR:   mscr_q   <= wr_data;
        A_MEPC:   mepc_q   <= wr_data;
        A_MCAUSE: mcause_q <= wr_data;
        A_MBAD:   mbad_q   <= wr_data;
        A_SEPC:   sepc_q   <= wr_data;
        A_SCAUSE: scause_q <= wr_data;
        A_SBAD:   sbad_q   <= wr_data;
        A_STVEC:  stvec_q  <= wr_data;
        A_SSCR:   sscr_q   <= wr_data;
        A_SPTB:   sptb_q   <= wr_data;
        A_UCEN:   ucen_q   <= wr_data[31:0];
        A_SCEN:   scen_q   <= wr_data[31:0];
        A_FLAGS:  flags_q  <= wr_data[4:0];
        A_RMODE:  rmode_q  <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ins_q <= '0;
    end else begin
      cyc_q <= (wr_en && wr_addr == A_MCYC) ? wr_data : cyc_q + 64'd1;
      if (wr_en && wr_addr == A_MINS) ins_q <= wr_data;
      else if (retire)                ins_q <= ins_q + 64'd1;
    end
  end

  logic        fp_ok;
  logic [63:0] ctr_sel, sview, sview_sd, scause_v;
  assign fp_ok    = HAS_FP && fp_en;
  assign ctr_sel  = (addr[1:0] == 2'd2) ? ins_q : cyc_q;
  assign sview    = mstat_q & SVIEW_MASK;
  assign sview_sd = (&sview[14:13] || &sview[16:15])
                    ? (sview | (xlen64 ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000))
                    : sview;
  assign scause_v = xlen64 ? scause_q : (scause_q | {32'b0, scause_q[63], 31'b0});

  logic [63:0] val;
  logic        ill;
  always_comb begin
    val = '0;
    ill = 1'b0;
    case (addr)
      A_FLAGS: if (fp_ok) val = {59'b0, flags_q}; else ill = 1'b1;
      A_RMODE: if (fp_ok) val = {61'b0, rmode_q}; else ill = 1'b1;
      A_FPALL: if (fp_ok) val = {56'b0, rmode_q, flags_q}; else ill = 1'b1;
      A_UCYC, A_UTIM, A_UINS: if (ucen_q[addr[4:0]]) val = ctr_sel; else ill = 1'b1;
      A_SCYC, A_STIM, A_SINS: if (scen_q[addr[4:0]]) val = ctr_sel; else ill = 1'b1;
      A_MCYC:  val = cyc_q;
      A_MINS:  val = ins_q;
      A_MCYCH: if (xlen64) ill = 1'b1; else val = {32'b0, cyc_q[63:32]};
      A_MINSH: if (xlen64) ill = 1'b1; else val = {32'b0, ins_q[63:32]};
      12'h700, 12'h701, 12'h702, 12'h704, 12'h705, 12'h706: val = '0;
      12'h780, 12'h781, 12'h782, 12'h784, 12'h785, 12'h786: ill = xlen64;
      A_UCEN:   val = {32'b0, ucen_q};
      A_SCEN:   val = {32'b0, scen_q};
      A_SSTAT:  val = sview_sd;
      A_SIP:    val = mip_q & idlg_q;
      A_SIE:    val = mie_q & idlg_q;
      A_SEPC:   val = sepc_q;
      A_SBAD:   val = sbad_q;
      A_STVEC:  val = stvec_q;
      A_SCAUSE: val = scause_v;
      A_SPTB:   val = sptb_q;
      A_SSCR:   val = sscr_q;
      A_SASID, A_MINJ, A_VEND, A_ARCH, A_IMPL: val = '0;
      A_MSTAT:  val = mstat_q;
      A_MIP:    val = mip_q;
      A_MIE:    val = mie_q;
      A_MEPC:   val = mepc_q;
      A_MSCR:   val = mscr_q;
      A_MCAUSE: val = mcause_q;
      A_MBAD:   val = mbad_q;
      A_ISA:    val = ISA_MASK;
      A_HART:   val = HART_ID;
      A_MTVEC:  val = mtvec_q;
      A_EDLG:   val = edlg_q;
      A_IDLG:   val = idlg_q;
      default:  ill = 1'b1;
    endcase
  end

  logic [63:0] rd_next;
  assign rd_next = ill ? 64'd0 : (xlen64 ? val : {32'b0, val[31:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
      illegal  <= 1'b0;
    end else begin
      rd_valid <= read_en;
      if (read_en) begin
        rdata   <= rd_next;
        illegal <= ill;
      end
    end
  end
endmodule

module csr_read_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        read_en,
  input logic [11:0] addr,
  input logic        xlen64,
  input logic        fp_en,
  input logic        wr_en,
  input logic        rd_valid,
  input logic [63:0] rdata,
  input logic        illegal,
  input logic [63:0] cyc_q
);
  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_en |=> rd_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !read_en |=> !rd_valid);
  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && !xlen64) |=> rdata[63:32] == 32'd0);
  // R5
  fp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && !fp_en && addr >= 12'h001 && addr <= 12'h003) |=> illegal);
  // R8
  high_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_en && xlen64 && (addr == 12'hB80 || addr == 12'hB82)) |=> illegal);
  // R8
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> cyc_q == $past(cyc_q) + 64'd1);
  // R12
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && illegal) |-> rdata == 64'd0);
endmodule

bind csr_read_unit csr_read_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .read_en(read_en), .addr(addr), .xlen64(xlen64),
  .fp_en(fp_en), .wr_en(wr_en), .rd_valid(rd_valid), .rdata(rdata),
  .illegal(illegal), .cyc_q(cyc_q)
);

// File: tb/tb_csr_read_unit.sv
module tb_csr_read_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] HART = 64'd3;
  localparam logic [63:0] ISA  = 64'h8000_0000_0014_112D;

  logic clk = 1'b0, rst_n = 1'b0, read_en = 1'b0, xlen64 = 1'b1, fp_en = 1'b1;
  logic retire = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0, wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic rd_valid, illegal;
  logic [63:0] rdata;

  csr_read_unit #(.HART_ID(HART), .ISA_MASK(ISA), .HAS_FP(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .read_en(read_en), .addr(addr), .xlen64(xlen64),
    .fp_en(fp_en), .retire(retire), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rdata(rdata), .illegal(illegal));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic x64, input logic fp,
                    output logic [63:0] d, output logic il);
    addr = a; xlen64 = x64; fp_en = fp; read_en = 1'b1;
    @(negedge clk);
    read_en = 1'b0;
    d = rdata; il = illegal;
    chk("R1 valid", {63'b0, rd_valid}, 64'd1);
  endtask

  typedef struct packed {
    logic [11:0] a;
    logic        x64;
    logic        fp;
    logic        ill;
    logic [3:0]  req;
    logic [63:0] d;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{12'h300, 1'b1, 1'b1, 1'b0, 4'd2,  64'hF0F0_0000_0000_6122}, // R2
    '{12'h300, 1'b0, 1'b1, 1'b0, 4'd2,  64'h0000_0000_0000_6122}, // R2
    '{12'h341, 1'b1, 1'b1, 1'b0, 4'd2,  64'h1234_5678_9ABC_DEF0}, // R2
    '{12'h341, 1'b0, 1'b1, 1'b0, 4'd2,  64'h0000_0000_9ABC_DEF0}, // R2
    '{12'h344, 1'b1, 1'b1, 1'b0, 4'd2,  64'h0000_0000_0000_0AAA}, // R2
    '{12'h100, 1'b1, 1'b1, 1'b0, 4'd3,  64'h8000_0000_0000_6122}, // R3
    '{12'h100, 1'b0, 1'b1, 1'b0, 4'd3,  64'h0000_0000_8000_6122}, // R3
    '{12'h144, 1'b1, 1'b1, 1'b0, 4'd4,  64'h0000_0000_0000_0222}, // R4
    '{12'h104, 1'b1, 1'b1, 1'b0, 4'd4,  64'h0000_0000_0000_0202}, // R4
    '{12'h001, 1'b1, 1'b1, 1'b0, 4'd5,  64'h13},                  // R5
    '{12'h002, 1'b1, 1'b1, 1'b0, 4'd5,  64'h5},                   // R5
    '{12'h003, 1'b1, 1'b1, 1'b0, 4'd5,  64'hB3},                  // R5
    '{12'h003, 1'b1, 1'b0, 1'b1, 4'd5,  64'h0},                   // R5
    '{12'h001, 1'b0, 1'b0, 1'b1, 4'd5,  64'h0},                   // R5
    '{12'h701, 1'b1, 1'b1, 1'b0, 4'd9,  64'h0},                   // R9
    '{12'h781, 1'b0, 1'b1, 1'b0, 4'd9,  64'h0},                   // R9
    '{12'h785, 1'b1, 1'b1, 1'b1, 4'd9,  64'h0},                   // R9
    '{12'hF11, 1'b1, 1'b1, 1'b0, 4'd10, 64'h0},                   // R10
    '{12'hF12, 1'b1, 1'b1, 1'b0, 4'd10, 64'h0},                   // R10
    '{12'hF13, 1'b1, 1'b1, 1'b0, 4'd10, 64'h0},                   // R10
    '{12'h345, 1'b1, 1'b1, 1'b0, 4'd10, 64'h0},                   // R10
    '{12'h181, 1'b1, 1'b1, 1'b0, 4'd10, 64'h0},                   // R10
    '{12'hF14, 1'b1, 1'b1, 1'b0, 4'd10, 64'd3},                   // R10
    '{12'h301, 1'b1, 1'b1, 1'b0, 4'd10, 64'h8000_0000_0014_112D}, // R10
    '{12'h142, 1'b1, 1'b1, 1'b0, 4'd11, 64'h8000_0000_0000_0005}, // R11
    '{12'h142, 1'b0, 1'b1, 1'b0, 4'd11, 64'h0000_0000_8000_0005}, // R11
    '{12'h7FF, 1'b1, 1'b1, 1'b1, 4'd12, 64'h0},                   // R12
    '{12'h000, 1'b1, 1'b1, 1'b1, 4'd12, 64'h0},                   // R12
    '{12'h320, 1'b1, 1'b1, 1'b0, 4'd6,  64'h5},                   // R6
    '{12'h321, 1'b1, 1'b1, 1'b0, 4'd7,  64'h2}                    // R7
  };

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic il;
    string m;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", {63'b0, rd_valid}, 64'd0);
    chk("R1 reset rdata", rdata, 64'd0);
    chk("R1 reset illegal", {63'b0, illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", {63'b0, rd_valid}, 64'd0);

    wr(12'h300, 64'hF0F0_0000_0000_6122);
    wr(12'h344, 64'h0AAA);
    wr(12'h304, 64'h0F0F);
    wr(12'h303, 64'h0222);
    wr(12'h341, 64'h1234_5678_9ABC_DEF0);
    wr(12'h142, 64'h8000_0000_0000_0005);
    wr(12'h001, 64'hFFF3);
    wr(12'h002, 64'hFD);
    wr(12'h320, 64'h5);
    wr(12'h321, 64'h2);

    for (int i = 0; i < NV; i++) begin
      rd(TBL[i].a, TBL[i].x64, TBL[i].fp, d, il);
      m = $sformatf("R%0d addr %h", TBL[i].req, TBL[i].a);
      chk({m, " illegal"}, {63'b0, il}, {63'b0, TBL[i].ill});
      chk({m, " data"}, d, TBL[i].d);
    end

    // R3 no summary bit; XS all ones sets it
    wr(12'h300, 64'h0000_0000_0004_2122);
    rd(12'h100, 1'b1, 1'b1, d, il); chk("R3 no sd", d, 64'h0000_0000_0004_2122);
    wr(12'h300, 64'h0000_0000_0001_8000);
    rd(12'h100, 1'b1, 1'b1, d, il); chk("R3 xs sd", d, 64'h8000_0000_0001_8000);

    // R13 writes to view and constant addresses are dropped
    wr(12'h100, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'hF11, 64'h55);
    rd(12'h300, 1'b1, 1'b1, d, il); chk("R13 mstatus kept", d, 64'h0000_0000_0001_8000);
    rd(12'hF11, 1'b1, 1'b1, d, il); chk("R13 vendor zero", d, 64'h0);

    // R6 user aliases, enable mask 0b101
    wr(12'hB00, 64'd100);
    rd(12'hC00, 1'b1, 1'b1, d, il); chk("R6 ucycle", d, 64'd100);
    rd(12'hC00, 1'b1, 1'b1, d, il); chk("R6 ucycle next", d, 64'd101);
    rd(12'hC01, 1'b1, 1'b1, d, il); chk("R6 utime gated", {63'b0, il}, 64'd1);
    // R7 supervisor aliases, enable mask 0b010
    rd(12'hD01, 1'b1, 1'b1, d, il); chk("R7 stime", d, 64'd103);
    rd(12'hD00, 1'b1, 1'b1, d, il); chk("R7 scycle gated", {63'b0, il}, 64'd1);

    // R8 retire counting
    wr(12'hB02, 64'd5);
    retire = 1'b1;
    repeat (3) @(negedge clk);
    retire = 1'b0;
    rd(12'hC02, 1'b1, 1'b1, d, il); chk("R8 instret", d, 64'd8);
    rd(12'hD02, 1'b1, 1'b1, d, il); chk("R7 sinstret gated", {63'b0, il}, 64'd1);
    rd(12'hB82, 1'b0, 1'b1, d, il); chk("R8 instret high", d, 64'd0);

    // R8 halves and carry in 32-bit mode
    wr(12'hB00, 64'h0000_0007_FFFF_FFFE);
    rd(12'hB80, 1'b0, 1'b1, d, il); chk("R8 high", d, 64'h7);
    rd(12'hB00, 1'b0, 1'b1, d, il); chk("R8 low", d, 64'hFFFF_FFFF);
    rd(12'hB80, 1'b0, 1'b1, d, il); chk("R8 high carry", d, 64'h8);
    rd(12'hB80, 1'b1, 1'b1, d, il); chk("R8 high wide illegal", {63'b0, il}, 64'd1);
    rd(12'hB00, 1'b1, 1'b1, d, il); chk("R8 wide", d, 64'h0000_0008_0000_0002);

    @(negedge clk);
    chk("R1 valid drops", {63'b0, rd_valid}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule